// File: doc/BRIEF.md
# PCM Serial Frame Interface

This block is the serial port of one codec channel. It moves 8-bit PCM code words between a parallel interface and two serial lines that are timed by an external bit clock. Frame syncs mark where each word starts. On the send side, a parallel word is loaded at the start of each frame and shifted out sign bit first. The data line is driven only while the word is on the line, so several channels can share it. On the receive side, eight serial bits are collected and the block presents them as one parallel word with a one-cycle strobe.

All inputs are sampled by a fast system clock. The bit clock, the frame syncs and the serial receive data must be synchronous to that clock and held for at least two system-clock cycles per level. Outputs are registered one system cycle after the input change that causes them. Two frame-sync timings are supported, short and long. The block selects between them from the width of the send frame sync. The selected timing applies from the following frame onward.

Top module: `pcm_frame_port`

## Requirements
- R1: After reset, `dx_oe` is 0, `dx` is 0, `rx_valid` is 0, `fs_err` is 0, and `long_mode` is 0 (0 selects short timing, 1 selects long timing).
- R2: In short timing, a frame begins when a falling `bclk` edge samples `fsx` high. The `bclk` rising edge after it sets `dx_oe` and drives bit 7 of the captured word. Each following rising edge moves to the next lower bit. `dx` only changes at rising edges, and it reads 0 whenever `dx_oe` is 0.
- R3: In short timing, `dx_oe` clears at the falling `bclk` edge after the rising edge that drove bit 0, and not before.
- R4: In short timing, the falling edge that samples `fsr` high latches no data. The next eight falling edges latch `dr`, first into `rx_word[7]` and last into `rx_word[0]`. The word appears with `rx_valid` high for exactly one cycle, and only after the eighth latch.
- R5: When `fsx` goes low, the number of falling `bclk` edges that sampled it high sets the timing: one selects short (`long_mode`=0), and three or more select long (`long_mode`=1). The decision governs later frames.
- R6: A send frame sync seen high on exactly two falling edges raises `fs_err` for one cycle, and `long_mode` keeps its value.
- R7: In long timing, `dx_oe` sets and bit 7 is driven at the later of two events: the rise of `fsx`, or a rising `bclk` edge.
- R8: In long timing, `dx_oe` clears at the later of two events: the falling `bclk` edge after the rising edge that drove bit 0, or `fsx` going low.
- R9: In long timing, the eight falling `bclk` edges after `fsr` rises latch `dr`, most significant bit first, and the word is presented as in R4.
- R10: `tx_word` is captured when `fsx` rises. Changing it later in the frame does not alter the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock |
| fsx | input | 1 | Send frame sync |
| fsr | input | 1 | Receive frame sync |
| dr | input | 1 | Serial receive data |
| tx_word | input | W | Parallel word to send |
| dx | output | 1 | Serial send data (0 while disabled) |
| dx_oe | output | 1 | Drive enable for `dx` |
| rx_word | output | W | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_word` |
| long_mode | output | 1 | Current frame timing, 1 = long |
| fs_err | output | 1 | One-cycle flag for a two-period frame sync |

## Verification
The bench drives a different value on `dr` during the short-timing sync fall than the word's first bit. A receiver that latched on that edge would return a word shifted by one bit. Long frames are run with `fsx` rising in both the high and the low half of `bclk`, and with `fsx` held past the last bit. An engine that always waited for a clock edge, or that dropped the enable without waiting for `fsx` to go low, would show the wrong enable at the checked edge. A two-period sync pulse is sent in each mode, which catches a detector that rounds that width up or down instead of holding its mode. `tx_word` is also overwritten in the middle of a frame, which exposes a shifter that reads the live input.

// File: rtl/pcm_frame_port.sv
module pcm_frame_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk,
  input  logic         fsx,
  input  logic         fsr,
  input  logic         dr,
  input  logic [W-1:0] tx_word,
  output logic         dx,
  output logic         dx_oe,
  output logic [W-1:0] rx_word,
  output logic         rx_valid,
  output logic         long_mode,
  output logic         fs_err
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] NLAST = CW'(W);
  localparam logic [CW-1:0] NPRE  = CW'(W - 1);

  typedef enum logic [2:0] {T_IDLE, T_WFALL, T_WRISE, T_SHIFT, T_DRAIN} tx_st_t;

  logic bclk_q, fsx_q, fsr_q;
  logic b_rise, b_fall, fsx_rise, fsx_fall, fsr_rise;

  assign b_rise   = bclk & ~bclk_q;
  assign b_fall   = ~bclk & bclk_q;
  assign fsx_rise = fsx & ~fsx_q;
  assign fsx_fall = ~fsx & fsx_q;
  assign fsr_rise = fsr & ~fsr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      fsx_q  <= 1'b0;
      fsr_q  <= 1'b0;
    end else begin
      bclk_q <= bclk;
      fsx_q  <= fsx;
      fsr_q  <= fsr;
    end
  end

  logic [1:0] fs_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_len    <= 2'd0;
      long_mode <= 1'b0;
      fs_err    <= 1'b0;
    end else begin
      fs_err <= 1'b0;
      if (fsx_rise)
        fs_len <= {1'b0, b_fall};
      else if (b_fall && fsx && fs_len != 2'd3)
        fs_len <= fs_len + 2'd1;
      if (fsx_fall) begin
        case (fs_len)
          2'd1:    long_mode <= 1'b0;
          2'd2:    fs_err    <= 1'b1;
          2'd3:    long_mode <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  tx_st_t        ts;
  logic [W-1:0]  sh;
  logic [CW-1:0] n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts    <= T_IDLE;
      sh    <= '0;
      n     <= '0;
      dx_oe <= 1'b0;
    end else if (fsx_rise) begin
      sh <= tx_word;
      if (long_mode && bclk) begin
        dx_oe <= 1'b1;
        n     <= 1;
        ts    <= T_SHIFT;
      end else begin
        dx_oe <= 1'b0;
        n     <= '0;
        ts    <= (long_mode || b_fall) ? T_WRISE : T_WFALL;
      end
    end else begin
      case (ts)
        T_WFALL: if (b_fall) ts <= fsx ? T_WRISE : T_IDLE;
        T_WRISE: if (b_rise) begin
          dx_oe <= 1'b1;
          n     <= 1;
          ts    <= T_SHIFT;
        end
        T_SHIFT: begin
          if (b_rise && n != NLAST) begin
            sh <= {sh[W-2:0], 1'b0};
            n  <= n + 1'b1;
          end else if (b_fall && n == NLAST) begin
            if (!long_mode || !fsx) begin
              dx_oe <= 1'b0;
              ts    <= T_IDLE;
            end else begin
              ts <= T_DRAIN;
            end
          end
        end
        T_DRAIN: if (!fsx) begin
          dx_oe <= 1'b0;
          ts    <= T_IDLE;
        end
        default: ts <= T_IDLE;
      endcase
    end
  end

  assign dx = dx_oe & sh[W-1];

  logic [W-1:0]  rsh;
  logic [CW-1:0] rn;
  logic          r_wait, r_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsh      <= '0;
      rn       <= '0;
      r_wait   <= 1'b0;
      r_act    <= 1'b0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (fsr_rise) begin
        r_act  <= long_mode;
        r_wait <= ~long_mode;
        rn     <= '0;
      end else if (r_wait && b_fall) begin
        r_wait <= 1'b0;
        r_act  <= fsr;
        rn     <= '0;
      end else if (r_act && b_fall) begin
        rsh <= {rsh[W-2:0], dr};
        rn  <= rn + 1'b1;
        if (rn == NPRE) begin
          rx_word  <= {rsh[W-2:0], dr};
          rx_valid <= 1'b1;
          r_act    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_frame_port_chk.sv
module pcm_frame_port_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk,
  input logic fsx,
  input logic dx,
  input logic dx_oe,
  input logic rx_valid,
  input logic long_mode,
  input logic fs_err
);
  // R4 and R9: the strobe lasts one cycle
  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R2 and R7: the enable only sets while the bit clock is high
  p_enable_on_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dx_oe) |-> $past(bclk));

  // R8: in long timing the enable never drops while the sync is still high
  p_disable_rule_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dx_oe) |-> (!$past(long_mode) || !$past(fsx)));

  // R2: serial data holds between rising bit-clock edges
  p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_oe && $past(dx_oe) && !($past(bclk) && !$past(bclk, 2))
     && !($past(fsx) && !$past(fsx, 2))) |-> $stable(dx));

  // R6: an ambiguous sync keeps the timing mode
  p_err_keeps_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fs_err |-> $stable(long_mode));
endmodule

bind pcm_frame_port pcm_frame_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsx(fsx), .dx(dx), .dx_oe(dx_oe),
  .rx_valid(rx_valid), .long_mode(long_mode), .fs_err(fs_err)
);

// File: tb/sim_pcm_frame_port.sv
module sim_pcm_frame_port;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, fsx = 1'b0, fsr = 1'b0, dr = 1'b0;
  logic [W-1:0] tx_word = '0;
  logic dx, dx_oe, rx_valid, long_mode, fs_err;
  logic [W-1:0] rx_word;
  int errs = 0, checks = 0, vcnt = 0;
  logic [W-1:0] vlast = '0;
  bit done = 1'b0;

  pcm_frame_port #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsx(fsx), .fsr(fsr), .dr(dr),
    .tx_word(tx_word), .dx(dx), .dx_oe(dx_oe), .rx_word(rx_word),
    .rx_valid(rx_valid), .long_mode(long_mode), .fs_err(fs_err)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (rx_valid) begin
    vcnt++;
    vlast = rx_word;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bhi(input logic d);
    @(negedge clk);
    bclk = 1'b1;
    dr   = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic blo();
    @(negedge clk);
    bclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle(input int k);
    repeat (k) begin
      bhi(1'b0);
      blo();
    end
  endtask

  task automatic tx_short(input logic [W-1:0] w);
    tx_word = w;
    bhi(1'b0);
    chk("R2 idle before sync", dx_oe, 0);
    fsx = 1'b1;
    blo();
    chk("R2 sync fall does not enable", dx_oe, 0);
    for (int i = 0; i < 8; i++) begin
      bhi(1'b0);
      chk("R2 enabled", dx_oe, 1);
      chk(i > 3 ? "R10 held word bit" : "R2 short bit", dx, w[7-i]);
      if (i == 0) fsx = 1'b0;
      if (i == 3) tx_word = ~w;
      blo();
      if (i < 7) chk("R3 not early", dx_oe, 1);
    end
    chk("R3 disabled after last bit", dx_oe, 0);
    chk("R5 stays short", long_mode, 0);
  endtask

  task automatic rx_short(input logic [W-1:0] w);
    int v0 = vcnt;
    bhi(~w[7]);
    fsr = 1'b1;
    blo();
    for (int i = 0; i < 8; i++) begin
      bhi(w[7-i]);
      if (i == 0) fsr = 1'b0;
      blo();
      if (i == 6) chk("R4 no early strobe", vcnt, v0);
    end
    chk("R4 one strobe", vcnt, v0 + 1);
    chk("R4 short word", vlast, w);
  endtask

  task automatic fs_pulse(input int k, input int e_err, input int e_mode);
    bhi(1'b0);
    fsx = 1'b1;
    repeat (k) begin
      blo();
      bhi(1'b0);
    end
    @(negedge clk) fsx = 1'b0;
    @(negedge clk);
    chk("R6 error flag", fs_err, e_err);
    chk("R5 mode decision", long_mode, e_mode);
    @(negedge clk);
    chk("R6 flag is a pulse", fs_err, 0);
    blo();
    idle(10);
  endtask

  task automatic tx_long_hi(input logic [W-1:0] w);
    tx_word = w;
    @(negedge clk) bclk = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 wait for sync", dx_oe, 0);
    fsx = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 enable at sync rise", dx_oe, 1);
    chk("R7 sign bit", dx, w[7]);
    blo();
    for (int i = 1; i < 8; i++) begin
      bhi(1'b0);
      chk("R7 long bit", dx, w[7-i]);
      if (i == 3) fsx = 1'b0;
      blo();
    end
    chk("R8 off at fall after last bit", dx_oe, 0);
    chk("R5 stays long", long_mode, 1);
  endtask

  task automatic tx_long_lo(input logic [W-1:0] w);
    tx_word = w;
    @(negedge clk) fsx = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 wait for clock rise", dx_oe, 0);
    for (int i = 0; i < 8; i++) begin
      bhi(1'b0);
      chk("R7 enabled", dx_oe, 1);
      chk("R7 long bit", dx, w[7-i]);
      blo();
    end
    chk("R8 held while sync high", dx_oe, 1);
    @(negedge clk) fsx = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 off at sync low", dx_oe, 0);
  endtask

  task automatic rx_long(input logic [W-1:0] w);
    int v0 = vcnt;
    bhi(w[7]);
    fsr = 1'b1;
    blo();
    for (int i = 1; i < 8; i++) begin
      bhi(w[7-i]);
      if (i == 3) fsr = 1'b0;
      blo();
    end
    chk("R9 one strobe", vcnt, v0 + 1);
    chk("R9 long word", vlast, w);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 enable", dx_oe, 0);
    chk("R1 data", dx, 0);
    chk("R1 strobe", rx_valid, 0);
    chk("R1 mode", long_mode, 0);
    chk("R1 error", fs_err, 0);
    idle(2);
    tx_short(8'hA5);
    idle(2);
    tx_short(8'h3C);
    rx_short(8'h4D);
    rx_short(8'hB2);
    fs_pulse(2, 1, 0);
    fs_pulse(3, 0, 1);
    tx_long_hi(8'hC3);
    idle(2);
    tx_long_lo(8'h5A);
    idle(2);
    rx_long(8'h96);
    rx_long(8'h71);
    fs_pulse(2, 1, 1);
    fs_pulse(1, 0, 0);
    tx_short(8'h81);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule